// File: doc/BRIEF.md
# Write-Burst Read-Interrupt Controller

This block sits on the controller side of a double-data-rate memory interface. It sequences a burst write onto the data bus and lets a later read request cut that burst short. A write request starts a burst of 2, 4 or 8 words. The words travel as pairs, one pair per clock and one word on each strobe edge. A read request that arrives while the burst is still on the bus becomes an interrupting read. Such a read may target any bank.

The block decides four things: which command goes out in each cycle, which word pairs carry the data mask, when the data and strobe drivers let go of the bus so it can turn around for read data, and how many words of the burst the memory actually keeps. It never lets a read follow a write by one clock. When a read would land in a forbidden slot, the block holds the read for one cycle and issues it in the next legal slot. The read-data capture path and all physical delay alignment are outside this block.

Top module: `wburst_rdcut`

## Requirements
- R1: The burst-length select `bl_sel` maps 3'b001 to 2 words, 3'b010 to 4 words and 3'b011 to 8 words, and maps any other code to 8 words. For a write command in cycle T, word pair k (k = 1 .. BL/2) is driven in cycle T+k, with `dq_oe` and `dqs_oe` high on every lane.
- R2: A request sampled on a clock edge puts its command on `cmd` after the following edge, so the command appears one cycle later. The encodings are NOP = 2'b00, WRITE = 2'b01 and READ = 2'b10, and `cmd_bank` carries the requested bank while a WRITE or READ is on `cmd`.
- R3: A READ never appears in the cycle right after a WRITE. A read that would land there is issued one cycle later.
- R4: A READ placed 2 .. BL/2 cycles after the WRITE interrupts the burst. It is issued with whatever bank was requested for it.
- R5: For an interrupting READ in cycle R, `dm` is high on both lanes for the pair driven in cycle R-1 and for every pair still driven from cycle R on. Pairs before R-1 are never masked, and `dm` is never high while the bus is not driven.
- R6: The CAS-latency select `cl_sel` maps 3'b010 to latency 2 and any other code to latency 3. After an interrupting READ in cycle R, the bus is driven no later than cycle R+CL-2, which leaves at least one undriven cycle before read data is due.
- R7: For a burst that runs to completion, a READ is never placed in the cycle right after the last pair; a read aiming there is issued one cycle later, giving two cycles from last data to read.
- R8: `words_done` reports the words the memory keeps from the latest write. It reads BL for a burst that completes, and 2*(R-T-2) for a burst interrupted by a READ in cycle R.
- R9: A write request is ignored while a burst is on the bus or in its one-cycle tail, and while a read is pending or requested in the same cycle. Only one delayed read is held, and further read requests while it waits are ignored.
- R10: After reset, `cmd` is NOP, all output enables and masks are low, and `words_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Request to start a write burst |
| rd_req | input | 1 | Request to issue a read |
| req_bank | input | 2 | Bank of the request in this cycle |
| bl_sel | input | 3 | Burst-length code |
| cl_sel | input | 3 | CAS-latency code |
| cmd | output | 2 | Command issued this cycle |
| cmd_bank | output | 2 | Bank of the issued command |
| dq_oe | output | 2 | Data driver enable, one bit per byte lane |
| dqs_oe | output | 2 | Strobe driver enable, one bit per byte lane |
| dm | output | 2 | Data mask, one bit per byte lane, held for both beats of a pair |
| words_done | output | 4 | Words kept from the latest write |

## Verification
The assertions take for granted that `bl_sel` and `cl_sel` change only while no burst is in flight. The tail-gap and release properties reason from the burst length and latency that were in force when the write started, so a mode change mid-burst would break them. The bench keeps to this rule by changing the mode codes only after at least ten idle cycles. It also keeps write requests apart by more than a full burst, except for the deliberately ignored ones.

// File: rtl/wburst_rdcut_pkg.sv
package wburst_rdcut_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_READ  = 2'b10
  } cmd_e;

  // word pairs per burst for a burst-length code
  function automatic int pairs_of(input logic [2:0] code);
    case (code)
      3'b001:  return 1;
      3'b010:  return 2;
      default: return 4;
    endcase
  endfunction

  // read latency in clocks for a latency code
  function automatic int latency_of(input logic [2:0] code);
    return (code == 3'b010) ? 2 : 3;
  endfunction
endpackage

// File: rtl/wburst_rdcut_sched.sv
module wburst_rdcut_sched
  import wburst_rdcut_pkg::*;
#(
  parameter int AW  = 4,
  parameter int BAW = 2,
  parameter int WW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_req,
  input  logic           rd_req,
  input  logic [BAW-1:0] req_bank,
  input  logic [AW-1:0]  pairs,
  output cmd_e           p_cmd,
  output logic [BAW-1:0] p_bank,
  output logic [AW-1:0]  p_age,
  output logic [AW-1:0]  p_cut,
  output logic           p_live,
  output logic           p_intr,
  output logic [WW-1:0]  words
);
  logic [AW-1:0]  a_n;
  logic           live_n, rd_want, slot_busy, rd_go, wr_go, intr;
  logic           pend;
  logic [BAW-1:0] pend_bank;

  always_comb begin
    a_n       = (p_age >= pairs + AW'(2)) ? p_age : p_age + AW'(1);
    live_n    = p_live && (a_n <= pairs + AW'(1));
    rd_want   = rd_req || pend;
    slot_busy = live_n && (p_cut == '0) && ((a_n == AW'(1)) || (a_n == pairs + AW'(1)));
    rd_go     = rd_want && !slot_busy;
    wr_go     = wr_req && !rd_want && !live_n;
    intr      = rd_go && live_n && (p_cut == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_cmd     <= CMD_NOP;
      p_bank    <= '0;
      p_age     <= '0;
      p_cut     <= '0;
      p_live    <= 1'b0;
      p_intr    <= 1'b0;
      words     <= '0;
      pend      <= 1'b0;
      pend_bank <= '0;
    end else begin
      p_cmd  <= rd_go ? CMD_READ : (wr_go ? CMD_WRITE : CMD_NOP);
      if (rd_go)      p_bank <= pend ? pend_bank : req_bank;
      else if (wr_go) p_bank <= req_bank;
      pend   <= rd_want && !rd_go;
      if (rd_req && !pend) pend_bank <= req_bank;
      p_intr <= intr;
      if (wr_go) begin
        p_age  <= '0;
        p_live <= 1'b1;
        p_cut  <= '0;
        words  <= WW'({pairs, 1'b0});
      end else begin
        p_age  <= a_n;
        p_live <= live_n;
        if (intr) begin
          p_cut <= a_n;
          words <= WW'({a_n - AW'(2), 1'b0});
        end
      end
    end
  end

  // R3
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_cmd == CMD_WRITE |=> p_cmd != CMD_READ);
  // R7
  tail_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_live && p_cut == '0 && p_age == pairs) |=> p_cmd != CMD_READ);
  // R9
  no_overlap_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_live && p_age <= pairs) |=> p_cmd != CMD_WRITE);
endmodule

// File: rtl/wburst_rdcut_stage.sv
module wburst_rdcut_stage
  import wburst_rdcut_pkg::*;
#(
  parameter int AW  = 4,
  parameter int BAW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  cmd_e           p_cmd,
  input  logic [BAW-1:0] p_bank,
  input  logic [AW-1:0]  p_age,
  input  logic [AW-1:0]  p_cut,
  input  logic           p_live,
  input  logic           p_intr,
  output cmd_e           o_cmd,
  output logic [BAW-1:0] o_bank,
  output logic [AW-1:0]  o_age,
  output logic [AW-1:0]  o_cut,
  output logic           o_live,
  output logic           o_intr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_cmd  <= CMD_NOP;
      o_bank <= '0;
      o_age  <= '0;
      o_cut  <= '0;
      o_live <= 1'b0;
      o_intr <= 1'b0;
    end else begin
      o_cmd  <= p_cmd;
      o_bank <= p_bank;
      o_age  <= p_age;
      o_cut  <= p_cut;
      o_live <= p_live;
      o_intr <= p_intr;
    end
  end
endmodule

// File: rtl/wburst_rdcut_lane.sv
module wburst_rdcut_lane (
  input  logic drive,
  input  logic mask,
  output logic dq_en,
  output logic dqs_en,
  output logic dm_bit
);
  assign dq_en  = drive;
  assign dqs_en = drive;
  assign dm_bit = drive && mask;
endmodule

// File: rtl/wburst_rdcut.sv
module wburst_rdcut
  import wburst_rdcut_pkg::*;
#(
  parameter int MAX_BL = 8,
  parameter int LANES  = 2,
  parameter int BAW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic             rd_req,
  input  logic [BAW-1:0]   req_bank,
  input  logic [2:0]       bl_sel,
  input  logic [2:0]       cl_sel,
  output logic [1:0]       cmd,
  output logic [BAW-1:0]   cmd_bank,
  output logic [LANES-1:0] dq_oe,
  output logic [LANES-1:0] dqs_oe,
  output logic [LANES-1:0] dm,
  output logic [$clog2(MAX_BL+1)-1:0] words_done
);
  localparam int MAXP = MAX_BL / 2;
  localparam int AW   = $clog2(MAXP + 3) + 1;
  localparam int WW   = $clog2(MAX_BL + 1);

  logic [AW-1:0]  pairs, hold_extra;
  cmd_e           p_cmd, o_cmd;
  logic [BAW-1:0] p_bank, o_bank;
  logic [AW-1:0]  p_age, p_cut, o_age, o_cut;
  logic           p_live, p_intr, o_live, o_intr;
  logic           drive_win, mask_win;

  assign pairs      = AW'(pairs_of(bl_sel));
  assign hold_extra = AW'(latency_of(cl_sel) - 2);

  wburst_rdcut_sched #(.AW(AW), .BAW(BAW), .WW(WW)) u_sched (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
    .req_bank(req_bank), .pairs(pairs), .p_cmd(p_cmd), .p_bank(p_bank),
    .p_age(p_age), .p_cut(p_cut), .p_live(p_live), .p_intr(p_intr),
    .words(words_done)
  );

  wburst_rdcut_stage #(.AW(AW), .BAW(BAW)) u_stage (
    .clk(clk), .rst_n(rst_n), .p_cmd(p_cmd), .p_bank(p_bank),
    .p_age(p_age), .p_cut(p_cut), .p_live(p_live), .p_intr(p_intr),
    .o_cmd(o_cmd), .o_bank(o_bank), .o_age(o_age), .o_cut(o_cut),
    .o_live(o_live), .o_intr(o_intr)
  );

  // drive window: burst pairs, cut off CL-2 cycles after an interrupting read
  assign drive_win = o_live && (o_age >= AW'(1)) && (o_age <= pairs) &&
                     ((o_cut == '0) || (o_age <= o_cut + hold_extra));
  // mask: pair before the read (read is next) and everything from the read on
  assign mask_win  = p_intr || ((o_cut != '0) && (o_age >= o_cut));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wburst_rdcut_lane u_lane (
      .drive(drive_win), .mask(mask_win),
      .dq_en(dq_oe[g]), .dqs_en(dqs_oe[g]), .dm_bit(dm[g])
    );
  end

  assign cmd      = o_cmd;
  assign cmd_bank = o_bank;

  // R5
  mask_at_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o_cmd == CMD_READ && o_intr) |-> dm == '1);
  // R5
  mask_needs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dm != '0 |-> dq_oe == dqs_oe && dq_oe != '0);
  // R6
  release_cl2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o_cmd == CMD_READ && o_intr && cl_sel == 3'b010) |=> dq_oe == '0);
  // R6
  release_cl3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o_cmd == CMD_READ && o_intr && cl_sel != 3'b010) |=> ##1 dq_oe == '0);
endmodule

// File: tb/wburst_rdcut_test.sv
`timescale 1ns/1ps
module wburst_rdcut_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_req = 1'b0, rd_req = 1'b0;
  logic [1:0] req_bank = '0;
  logic [2:0] bl_sel = 3'b001, cl_sel = 3'b010;
  logic [1:0] cmd, cmd_bank, dq_oe, dqs_oe, dm;
  logic [3:0] words_done;
  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wburst_rdcut uut (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
    .req_bank(req_bank), .bl_sel(bl_sel), .cl_sel(cl_sel), .cmd(cmd),
    .cmd_bank(cmd_bank), .dq_oe(dq_oe), .dqs_oe(dqs_oe), .dm(dm),
    .words_done(words_done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_pairs(input logic [2:0] c);
    return (c == 3'b001) ? 1 : (c == 3'b010) ? 2 : 4;
  endfunction

  function automatic int exp_cl(input logic [2:0] c);
    return (c == 3'b010) ? 2 : 3;
  endfunction

  function automatic int exp_age(input int d, input int p);
    int r = d;
    while (r == 1 || r == p + 1) r++;
    return r;
  endfunction

  task automatic run_trial(input logic [2:0] blc, input logic [2:0] clc,
                           input int d, input bit extra);
    int p = exp_pairs(blc);
    int cl = exp_cl(clc);
    int r = exp_age(d, p);
    bit intr = (r <= p);
    int rb = (d + 2) % 4;
    @(negedge clk);
    wr_req = 0; rd_req = 0; bl_sel = blc; cl_sel = clc;
    repeat (10) @(negedge clk);
    for (int k = 0; k <= p + 8; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        int a = k - 2;
        int ecmd = (a == 0) ? 1 : (a == r) ? 2 : 0;
        bit eoe = (a >= 1) && (a <= p) && (!intr || a <= r + cl - 2);
        bit edm = eoe && intr && (a >= r - 1);
        string ctag = (d == 1) ? "R3" : (d == p + 1) ? "R7" : extra ? "R9" : "R2";
        chk(ctag, cmd, ecmd);
        if (ecmd == 2) chk("R4", cmd_bank, rb);
        if (ecmd == 1) chk("R2", cmd_bank, 1);
        chk((intr && a > r) ? "R6" : "R1", dq_oe, eoe ? 3 : 0);
        chk("R1", dqs_oe, eoe ? 3 : 0);
        chk("R5", dm, edm ? 3 : 0);
      end
      wr_req   = (k == 0) || (extra && k == 2);
      rd_req   = (k == d) || (d == 1 && k == 2);
      req_bank = (k == 0) ? 2'd1 : (k == d) ? 2'(rb) : 2'(rb ^ 3);
    end
    chk("R8", words_done, intr ? 2 * (r - 2) : 2 * p);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [2:0] blcodes [4] = '{3'b001, 3'b010, 3'b011, 3'b111};
    logic [2:0] clcodes [3] = '{3'b010, 3'b011, 3'b000};
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", cmd, 0);
    chk("R10", dq_oe, 0);
    chk("R10", dm, 0);
    chk("R10", words_done, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10", dqs_oe, 0);
    for (int b = 0; b < 4; b++)
      for (int c = 0; c < 3; c++) begin
        int p = exp_pairs(blcodes[b]);
        for (int d = 1; d <= p + 3; d++)
          run_trial(blcodes[b], clcodes[c], d, d == p + 3);
      end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule